// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block drives four independent pulse outputs from one clock. Software configures it through a small synchronous register bus. Each channel has four settings: an enable bit, a step-clock prescale choice, a period counted in steps (the timebase) and a high time counted in the same steps (the duty). Each output goes high at the start of every period and stays high for the duty part of it. The conversion from time units to register values is done in software.

Settings that change while a channel runs are held in a per-channel shadow copy. The copy takes the new values only at the next period boundary, so every period on the output is whole. A disabled channel drives low and resets its counters. Enabling it starts a fresh period at once. Every defined field reads back as written, so software can save and restore the whole state.

Top module: `pwm_quad`

## Requirements
- R1: The control register sits at offset 0x0. Its bit n (n = 0..3) enables channel n, and each channel runs on its own. Writing the bit to 0 makes output n low from the cycle after the write edge, and a channel whose bit is 0 never drives high.
- R2: The prescale code of channel n is control bits [2n+5:2n+4]. One step lasts 1 clock cycle for code 0, 8 for code 1, 64 for code 2 and 512 for code 3.
- R3: The configuration register of channel n sits at offset 0x4+4n. The timebase is bits [7:0] and the duty is bits [23:16]. One period lasts timebase steps, and the timebase can be as large as 255.
- R4: While a channel is enabled, its output is high for the first duty steps of each period and low for the rest. Periods follow each other back to back, counted from the enable edge.
- R5: A duty of 0 keeps the output low. A duty equal to or greater than the timebase keeps it high for as long as the channel is enabled.
- R6: A timebase of 0 keeps the output low.
- R7: Timebase, duty or prescale values written while a channel runs take effect at the next period boundary. The period in progress finishes with the old values.
- R8: Setting an enable bit starts a fresh period at step 0 from the cycle after the write edge. The new period uses the values currently in the registers.
- R9: Reading a register returns its fields as written. Control bits [31:12] and configuration bits [15:8] and [31:24] read as 0.
- R10: A write to an offset that is not 0x0, 0x4, 0x8, 0xC or 0x10 changes nothing, and such an offset reads as 0.
- R11: After reset, all registers read 0 and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus and the pulse generation |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 5 | Byte offset of the register being accessed |
| bus_we | input | 1 | Write strobe, taken on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register, combinational |
| pwm_out | output | 4 | Pulse outputs, bit n belongs to channel n |

## Verification
The bench builds the block with its default values: four channels, an 8-bit timebase and duty, and a 2-bit prescale code. The prescale code is the only value that stretches a run, so the bench does use it. The longest case is the 512-cycle step, where one whole period of timebase 2 takes 1024 cycles. The bench also covers the largest timebase of 255 and a duty above the timebase. It counts high cycles over windows that start at the enable edge, so every period boundary and every shadow reload falls on a cycle the bench knows in advance.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
    localparam int NUM_CH    = 4;
    localparam int TB_W      = 8;
    localparam int SEL_W     = 2;
    localparam int STAGE_LOG = 3;
    localparam int PRE_W     = STAGE_LOG * ((1 << SEL_W) - 1);
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 5;

    typedef struct packed {
        logic [TB_W-1:0] duty;
        logic [TB_W-1:0] tb;
    } ch_cfg_t;

    typedef struct packed {
        logic [NUM_CH-1:0]            en;
        logic [NUM_CH-1:0][SEL_W-1:0] sel;
        ch_cfg_t [NUM_CH-1:0]         cfg;
    } reg_state_t;

    typedef struct packed {
        logic             run;
        logic [PRE_W-1:0] pre;
        logic [TB_W-1:0]  cnt;
        logic [SEL_W-1:0] sel;
        ch_cfg_t          cfg;
    } chan_state_t;
endpackage

// File: rtl/pwm_quad_regs.sv
module pwm_quad_regs
    import pwm_quad_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output reg_state_t        regs_o
);
    localparam int CTRL_OFS  = 0;
    localparam int CH_BASE   = 4;
    localparam int CH_STRIDE = 4;
    localparam int EN_LSB    = 0;
    localparam int SEL_LSB   = NUM_CH;
    localparam int TB_LSB    = 0;
    localparam int DUTY_LSB  = 16;

    reg_state_t regs_d, regs_q;
    logic       unused_wbits;

    assign unused_wbits = ^wdata;

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            if (addr == ADDR_W'(CTRL_OFS)) begin
                for (int n = 0; n < NUM_CH; n++) begin
                    regs_d.en[n]  = wdata[EN_LSB + n];
                    regs_d.sel[n] = wdata[SEL_LSB + SEL_W*n +: SEL_W];
                end
            end
            for (int n = 0; n < NUM_CH; n++) begin
                if (addr == ADDR_W'(CH_BASE + CH_STRIDE*n)) begin
                    regs_d.cfg[n].tb   = wdata[TB_LSB +: TB_W];
                    regs_d.cfg[n].duty = wdata[DUTY_LSB +: TB_W];
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(CTRL_OFS)) begin
            for (int n = 0; n < NUM_CH; n++) begin
                rdata[EN_LSB + n]                  = regs_q.en[n];
                rdata[SEL_LSB + SEL_W*n +: SEL_W]  = regs_q.sel[n];
            end
        end
        for (int n = 0; n < NUM_CH; n++) begin
            if (addr == ADDR_W'(CH_BASE + CH_STRIDE*n)) begin
                rdata[TB_LSB +: TB_W]   = regs_q.cfg[n].tb;
                rdata[DUTY_LSB +: TB_W] = regs_q.cfg[n].duty;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs_o = regs_q;
endmodule

// File: rtl/pwm_quad_chan.sv
module pwm_quad_chan
    import pwm_quad_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] sel_live,
    input  ch_cfg_t          cfg_live,
    output logic             pwm_o
);
    chan_state_t      st_d, st_q;
    logic [SEL_W-1:0] eff_sel;
    ch_cfg_t          eff_cfg;
    logic [PRE_W-1:0] pre_lim;
    logic             step_tick;
    logic             last_step;
    logic             boundary;

    always_comb begin
        // A running channel works from its shadow; an idle one follows the registers.
        eff_sel   = st_q.run ? st_q.sel : sel_live;
        eff_cfg   = st_q.run ? st_q.cfg : cfg_live;
        pre_lim   = PRE_W'((1 << (STAGE_LOG * int'(eff_sel))) - 1);
        step_tick = (st_q.pre == pre_lim);
        last_step = (({1'b0, st_q.cnt} + 1'b1) >= {1'b0, eff_cfg.tb});
        boundary  = step_tick && last_step;

        st_d     = st_q;
        st_d.run = en;
        if (!st_q.run || boundary) begin
            st_d.sel = sel_live;
            st_d.cfg = cfg_live;
        end
        if (!en) begin
            st_d.pre = '0;
            st_d.cnt = '0;
        end else begin
            st_d.pre = step_tick ? '0 : st_q.pre + 1'b1;
            if (boundary) begin
                st_d.cnt = '0;
            end else if (step_tick) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end

        pwm_o = en && (eff_cfg.tb != '0) && (st_q.cnt < eff_cfg.duty);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
    import pwm_quad_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    reg_state_t regs;

    pwm_quad_regs regs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (bus_addr),
        .we     (bus_we),
        .wdata  (bus_wdata),
        .rdata  (bus_rdata),
        .regs_o (regs)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_quad_chan chan_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (regs.en[g]),
            .sel_live (regs.sel[g]),
            .cfg_live (regs.cfg[g]),
            .pwm_o    (pwm_out[g])
        );
    end
endmodule

// File: rtl/pwm_quad_chk.sv
module pwm_quad_chk
    import pwm_quad_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NUM_CH-1:0] pwm_out,
    input reg_state_t        regs
);
    localparam int          LAST_OFS  = 4 * NUM_CH;
    localparam logic [31:0] CTRL_MASK = (32'd1 << (NUM_CH + NUM_CH*SEL_W)) - 1;

    logic undef_addr;
    assign undef_addr = (bus_addr[1:0] != 2'b00) || (int'(bus_addr) > LAST_OFS);

    // R9
    ctrl_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == '0) |=>
        ((bus_addr != '0) || (bus_rdata == ($past(bus_wdata) & CTRL_MASK))));

    // R10
    undef_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && undef_addr) |=> $stable(regs));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_prop
        // R1
        disable_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_addr == '0 && !bus_wdata[g]) |=> !pwm_out[g]);

        // R1
        high_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pwm_out[g] |-> regs.en[g]);

        // R8
        restart_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(regs.en[g]) && regs.cfg[g].duty != '0 && regs.cfg[g].tb != '0)
            |-> pwm_out[g]);
    end
endmodule

bind pwm_quad pwm_quad_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out),
    .regs      (regs)
);

// File: tb/pwm_quad_tb_top.sv
module pwm_quad_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 10;
    // columns: timebase, duty, prescale code, window cycles, expected high cycles, requirement
    localparam int VEC [N_VEC][6] = '{
        '{10,   3, 0,   30,   9, 4},  // R4 three whole periods
        '{10,   0, 0,   20,   0, 5},  // R5 duty zero
        '{10,  10, 0,   20,  20, 5},  // R5 duty equal to timebase
        '{10, 200, 0,   20,  20, 5},  // R5 duty above timebase
        '{ 0,   5, 0,   20,   0, 6},  // R6 timebase zero
        '{ 4,   1, 1,   64,  16, 2},  // R2 divide by 8
        '{ 3,   2, 2,  384, 256, 2},  // R2 divide by 64
        '{ 2,   1, 3, 1024, 512, 2},  // R2 divide by 512
        '{255,128, 0,  255, 128, 3},  // R3 largest timebase
        '{ 5,   2, 0,   12,   6, 4}   // R4 window ends mid-period
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_quad dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = 5'(a);
        bus_we    = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        bus_addr = 5'(a);
        #1;
        d = int'(bus_rdata);
    endtask

    task automatic count_high(input int ch, input int win, output int hi);
        hi = 0;
        repeat (win) begin
            if (pwm_out[ch]) hi++;
            @(negedge clk);
        end
    endtask

    initial begin
        int v;
        int hi;
        int h0;
        int h3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        check("R11 outputs", int'(pwm_out), 0);
        rd(0, v); check("R11 ctrl", v, 0);
        rd(4, v); check("R11 ch0 cfg", v, 0);

        // vector table
        for (int r = 0; r < N_VEC; r++) begin
            int ch;
            ch = r % 4;
            wr(0, 32'h0);
            wr(4 + 4*ch, 32'((VEC[r][1] << 16) | VEC[r][0]));
            wr(0, 32'((1 << ch) | (VEC[r][2] << (4 + 2*ch))));
            count_high(ch, VEC[r][3], hi);
            check($sformatf("R%0d row %0d", VEC[r][5], r), hi, VEC[r][4]);
        end
        wr(0, 32'h0);

        // R7 update mid-period waits for the boundary
        wr(4, 32'h0003_000A);
        wr(0, 32'h1);
        h0 = 0;
        h3 = 0;
        for (int i = 0; i < 20; i++) begin
            if (pwm_out[0]) begin
                if (i < 10) h0++; else h3++;
            end
            if (i == 4) begin
                bus_addr = 5'd4; bus_we = 1'b1; bus_wdata = 32'h0007_000A;
            end
            if (i == 5) bus_we = 1'b0;
            @(negedge clk);
        end
        check("R7 old period", h0, 3);
        check("R7 new period", h3, 7);
        wr(0, 32'h0);

        // R1 disable mid-period, R8 restart
        wr(8, 32'h0005_000A);
        wr(0, 32'h2);
        repeat (7) @(negedge clk);
        wr(0, 32'h0);
        check("R1 low after disable", int'(pwm_out[1]), 0);
        repeat (3) @(negedge clk);
        check("R1 stays low", int'(pwm_out[1]), 0);
        wr(0, 32'h2);
        check("R8 first step high", int'(pwm_out[1]), 1);
        count_high(1, 10, hi);
        check("R8 fresh period", hi, 5);
        wr(0, 32'h0);

        // R1 two channels at once
        wr(4, 32'h0001_0004);
        wr(16, 32'h0006_0008);
        wr(0, 32'h9);
        h0 = 0;
        h3 = 0;
        for (int i = 0; i < 8; i++) begin
            if (pwm_out[0]) h0++;
            if (pwm_out[3]) h3++;
            if (pwm_out[1] || pwm_out[2]) h0 += 100;
            @(negedge clk);
        end
        check("R1 ch0 alongside ch3", h0, 2);
        check("R1 ch3 alongside ch0", h3, 6);
        wr(0, 32'h0);

        // R9 readback with unused bits zero, R3 field positions
        wr(0, 32'hFFFF_FFFF);
        rd(0, v); check("R9 ctrl mask", v, 32'h0000_0FFF);
        wr(0, 32'h0000_0B64);
        rd(0, v); check("R9 ctrl value", v, 32'h0000_0B64);
        wr(0, 32'h0);
        wr(8, 32'hFFFF_FFFF);
        rd(8, v); check("R9 cfg mask", v, 32'h00FF_00FF);
        wr(16, 32'h1234_5678);
        rd(16, v); check("R3 cfg fields", v, 32'h0034_0078);

        // R10 undefined offsets
        wr(20, 32'hFFFF_FFFF);
        wr(2, 32'hFFFF_FFFF);
        wr(29, 32'hFFFF_FFFF);
        rd(0, v);  check("R10 ctrl untouched", v, 0);
        rd(16, v); check("R10 ch3 untouched", v, 32'h0034_0078);
        rd(8, v);  check("R10 ch1 untouched", v, 32'h00FF_00FF);
        rd(20, v); check("R10 reads zero", v, 0);
        rd(2, v);  check("R10 misaligned reads zero", v, 0);
        check("R10 outputs low", int'(pwm_out), 0);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule